// File: doc/BRIEF.md
# Multichannel SPI ADC Scan Controller

This block is the SPI master for an eight-input, 12-bit serial converter. It runs without software. After reset it programs the converter once so that it uses its internal voltage reference. It then cycles through the inputs 0 to 7 without stopping. Each input gets a select command. The block then waits for the converter to pull its active-low end-of-conversion line and reads the result back. A bank of per-channel registers always holds the newest value of every input.

Every transfer is a 16-bit frame. The top four bits are a command nibble and the low twelve bits are the payload. The converter returns the result of the conversion it finished last in the first twelve clocks of the next frame, MSB first. The block therefore pipelines the work: the frame that selects channel k also carries back the sample of channel k-1. A floor on frame-start spacing keeps the command rate within the converter's 200 ksps limit. If end-of-conversion never arrives, a timeout prevents the scan from stalling.

Top module: `adc_scan_ctrl`

## Requirements
- R1: While reset is held, `adc_cs_no` is 1, `adc_sclk_o` is 0, `scan_done_o` and `timeout_o` are 0, and all result registers read 0.
- R2: The first frame after reset is the configuration frame 16'hA800: command nibble 4'hA, with payload bit 11 (internal reference) set and all other payload bits 0. It is sent once and only once per reset.
- R3: Every later frame is a select frame. Its top nibble holds the channel number 0..7 and its low 12 bits are zero. Channels are selected in the order 0,1,...,7 and the order then wraps to 0.
- R4: Each frame holds `adc_cs_no` low for exactly 16 rising edges of `adc_sclk_o`. `adc_sclk_o` idles low. MOSI sends the frame MSB first and changes only while SCLK is low. MISO is sampled on SCLK rising edges.
- R5: After a select frame, the next frame does not begin before `adc_eoc_ni` has gone low, unless that channel times out.
- R6: The first 12 MISO bits of the frame that follows channel n's select frame are written to result slot n, whose bits are [12n+11:12n] of `result_o`.
- R7: Consecutive falling edges of `adc_cs_no` are at least SPACING clocks apart.
- R8: If end-of-conversion does not arrive within TIMEOUT clocks of a select frame's end, `timeout_o` pulses for one cycle and the scan moves on to the next channel. That channel's register keeps its old value, and the stale readback is discarded.
- R9: `scan_done_o` pulses for one cycle, once per scan, in the same cycle that channel 7's slot is resolved. The slot is resolved when its result becomes visible in `result_o` or when channel 7 times out.
- R10: A reset during operation clears all result registers. Once reset is released, the controller begins again with the configuration frame and channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adc_cs_no | output | 1 | Converter chip select, active low |
| adc_sclk_o | output | 1 | Serial clock, idles low |
| adc_mosi_o | output | 1 | Serial data to the converter |
| adc_miso_i | input | 1 | Serial data from the converter |
| adc_eoc_ni | input | 1 | End-of-conversion, active low, asynchronous |
| result_o | output | 96 | Result bank, channel n in bits [12n+11:12n] |
| scan_done_o | output | 1 | One-cycle pulse when channel 7's slot is resolved |
| timeout_o | output | 1 | One-cycle pulse when a channel misses end-of-conversion |

## Verification
The bench uses a converter model whose end-of-conversion delay sometimes exceeds the spacing floor and sometimes falls short of it. A controller that paced itself on the timer alone would open the next frame while `adc_eoc_ni` was still high. Some scans drop channel 3 or channel 7. If the stale readback that follows a dropped channel were written, the register of the previous channel would be corrupted. If `scan_done_o` were tied only to the ch7 result write, it would go missing in the scan where channel 7 times out. A reset in the middle of a frame then checks that a truncated frame is not decoded and that configuration is sent again.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [2:0] {
    ST_CFG,
    ST_CFG_XFER,
    ST_GAP,
    ST_SEL_XFER,
    ST_EOC
  } seq_state_e;
endpackage

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
  parameter int FRAME_W  = 16,
  parameter int RES_W    = 12,
  parameter int HALF_DIV = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] tx_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [RES_W-1:0]   rx_o,
  output logic               cs_no,
  output logic               sclk_o,
  output logic               mosi_o,
  input  logic               miso_i
);
  localparam int DIV_W = $clog2(HALF_DIV + 1);
  localparam int BIT_W = $clog2(FRAME_W + 1);

  logic               busy_q, done_q, cs_q, sclk_q;
  logic [DIV_W-1:0]   div_q;
  logic [BIT_W-1:0]   bit_q;
  logic [FRAME_W-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        cs_q   <= 1'b0;
        sclk_q <= 1'b0;
        tx_q   <= tx_i;
        div_q  <= '0;
        bit_q  <= '0;
      end else if (busy_q) begin
        if (div_q == DIV_W'(HALF_DIV - 1)) begin
          div_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[FRAME_W-2:0], miso_i};
          end else begin
            sclk_q <= 1'b0;
            tx_q   <= {tx_q[FRAME_W-2:0], 1'b0};
            if (bit_q == BIT_W'(FRAME_W - 1)) begin
              busy_q <= 1'b0;
              cs_q   <= 1'b1;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  // result occupies the first RES_W bits clocked in
  assign rx_o   = rx_q[FRAME_W-1 -: RES_W];
  assign cs_no  = cs_q;
  assign sclk_o = sclk_q;
  assign mosi_o = tx_q[FRAME_W-1];

  p_sclk_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q |-> !sclk_q);
  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_cs_from_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_q) |-> $past(start_i));
  p_mosi_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_q) |-> $stable(mosi_o));
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import adc_scan_pkg::*;
#(
  parameter int          NUM_CH   = 8,
  parameter int          RES_W    = 12,
  parameter int          CMD_W    = 4,
  parameter int          SPACING  = 250,
  parameter int          TIMEOUT  = 64,
  parameter logic [3:0]  CFG_CMD  = 4'hA,
  parameter logic [11:0] CFG_WORD = 12'h800,
  localparam int         CH_W     = $clog2(NUM_CH),
  localparam int         FRAME_W  = CMD_W + RES_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic               start_o,
  output logic [FRAME_W-1:0] tx_o,
  input  logic               done_i,
  input  logic [RES_W-1:0]   rx_i,
  input  logic               eoc_i,
  output logic               wr_en_o,
  output logic [CH_W-1:0]    wr_ch_o,
  output logic [RES_W-1:0]   wr_data_o,
  output logic               scan_done_o,
  output logic               timeout_o
);
  localparam int GAP_W  = $clog2(SPACING);
  localparam int WAIT_W = $clog2(TIMEOUT);

  seq_state_e       state_q;
  logic [CH_W-1:0]  ch_q, pend_ch_q;
  logic             pend_valid_q;
  logic [GAP_W-1:0] gap_q;
  logic [WAIT_W-1:0] wait_q;
  logic             scan_done_q, timeout_q;
  logic             gap_ok, last_ch;

  assign gap_ok  = (gap_q == GAP_W'(SPACING - 1));
  assign last_ch = (ch_q == CH_W'(NUM_CH - 1));

  always_comb begin
    start_o = (state_q == ST_CFG) || (state_q == ST_GAP && gap_ok);
    if (state_q == ST_CFG) tx_o = {CMD_W'(CFG_CMD), RES_W'(CFG_WORD)};
    else                   tx_o = {CMD_W'(ch_q), RES_W'(0)};
  end

  assign wr_en_o   = (state_q == ST_SEL_XFER) && done_i && pend_valid_q;
  assign wr_ch_o   = pend_ch_q;
  assign wr_data_o = rx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gap_q <= '0;
    else if (start_o) gap_q <= '0;
    else if (!gap_ok) gap_q <= gap_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_CFG;
      ch_q         <= '0;
      pend_ch_q    <= '0;
      pend_valid_q <= 1'b0;
      wait_q       <= '0;
      scan_done_q  <= 1'b0;
      timeout_q    <= 1'b0;
    end else begin
      scan_done_q <= 1'b0;
      timeout_q   <= 1'b0;
      case (state_q)
        ST_CFG: state_q <= ST_CFG_XFER;
        ST_CFG_XFER: if (done_i) begin
          state_q      <= ST_GAP;
          ch_q         <= '0;
          pend_valid_q <= 1'b0;
        end
        ST_GAP: if (gap_ok) state_q <= ST_SEL_XFER;
        ST_SEL_XFER: if (done_i) begin
          if (pend_valid_q && pend_ch_q == CH_W'(NUM_CH - 1)) scan_done_q <= 1'b1;
          state_q <= ST_EOC;
          wait_q  <= '0;
        end
        ST_EOC: begin
          if (eoc_i || wait_q == WAIT_W'(TIMEOUT - 1)) begin
            pend_valid_q <= eoc_i;
            pend_ch_q    <= ch_q;
            ch_q         <= last_ch ? '0 : ch_q + 1'b1;
            state_q      <= ST_GAP;
            if (!eoc_i) begin
              timeout_q <= 1'b1;
              if (last_ch) scan_done_q <= 1'b1;
            end
          end else begin
            wait_q <= wait_q + 1'b1;
          end
        end
        default: state_q <= ST_CFG;
      endcase
    end
  end

  assign scan_done_o = scan_done_q;
  assign timeout_o   = timeout_q;

  p_scan_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_done_q |=> !scan_done_q);
  p_timeout_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_q |=> !timeout_q);
  p_start_needs_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EOC && !eoc_i && wait_q != WAIT_W'(TIMEOUT - 1)) |=> state_q == ST_EOC);
  p_write_after_select_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> pend_ch_q == (ch_q == '0 ? CH_W'(NUM_CH - 1) : ch_q - 1'b1));
endmodule

// File: rtl/result_bank.sv
module result_bank #(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 12,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [CH_W-1:0]         wr_ch_i,
  input  logic [RES_W-1:0]        wr_data_i,
  output logic [NUM_CH*RES_W-1:0] result_o
);
  logic [NUM_CH-1:0] we;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
    logic [RES_W-1:0] slot_q;
    assign we[i] = wr_en_i && (wr_ch_i == CH_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    slot_q <= '0;
      else if (we[i]) slot_q <= wr_data_i;
    end
    assign result_o[i*RES_W +: RES_W] = slot_q;
  end

  p_one_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we));
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
  parameter int          NUM_CH   = 8,
  parameter int          RES_W    = 12,
  parameter int          CMD_W    = 4,
  parameter int          HALF_DIV = 2,
  parameter int          SPACING  = 250,
  parameter int          TIMEOUT  = 64,
  parameter logic [3:0]  CFG_CMD  = 4'hA,
  parameter logic [11:0] CFG_WORD = 12'h800
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  output logic                    adc_cs_no,
  output logic                    adc_sclk_o,
  output logic                    adc_mosi_o,
  input  logic                    adc_miso_i,
  input  logic                    adc_eoc_ni,
  output logic [NUM_CH*RES_W-1:0] result_o,
  output logic                    scan_done_o,
  output logic                    timeout_o
);
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int FRAME_W = CMD_W + RES_W;
  localparam int SP_W    = $clog2(SPACING + 1);

  logic               start, busy, done;
  logic [FRAME_W-1:0] tx;
  logic [RES_W-1:0]   rx, wr_data;
  logic               wr_en;
  logic [CH_W-1:0]    wr_ch;
  logic [1:0]         eoc_sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eoc_sync_q <= 2'b11;
    else         eoc_sync_q <= {eoc_sync_q[0], adc_eoc_ni};
  end

  spi_frame_engine #(.FRAME_W(FRAME_W), .RES_W(RES_W), .HALF_DIV(HALF_DIV)) u_spi (
    .clk_i, .rst_ni,
    .start_i(start), .tx_i(tx), .busy_o(busy), .done_o(done), .rx_o(rx),
    .cs_no(adc_cs_no), .sclk_o(adc_sclk_o), .mosi_o(adc_mosi_o), .miso_i(adc_miso_i)
  );

  scan_sequencer #(
    .NUM_CH(NUM_CH), .RES_W(RES_W), .CMD_W(CMD_W), .SPACING(SPACING),
    .TIMEOUT(TIMEOUT), .CFG_CMD(CFG_CMD), .CFG_WORD(CFG_WORD)
  ) u_seq (
    .clk_i, .rst_ni,
    .start_o(start), .tx_o(tx), .done_i(done), .rx_i(rx), .eoc_i(!eoc_sync_q[1]),
    .wr_en_o(wr_en), .wr_ch_o(wr_ch), .wr_data_o(wr_data),
    .scan_done_o, .timeout_o
  );

  result_bank #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_bank (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_ch_i(wr_ch), .wr_data_i(wr_data), .result_o
  );

  // frame-rate window, checked with a counter rather than a deep $past
  logic            cs_d_q, seen_q;
  logic [SP_W-1:0] since_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d_q  <= 1'b1;
      seen_q  <= 1'b0;
      since_q <= '0;
    end else begin
      cs_d_q <= adc_cs_no;
      if (cs_d_q && !adc_cs_no) begin
        since_q <= SP_W'(1);
        seen_q  <= 1'b1;
      end else if (since_q != SP_W'(SPACING)) begin
        since_q <= since_q + 1'b1;
      end
    end
  end

  p_spacing_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_d_q && !adc_cs_no && seen_q) |-> since_q >= SP_W'(SPACING));
  p_no_start_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> !busy);
endmodule

// File: tb/adc_scan_ctrl_test.sv
`timescale 1ns/1ps
module adc_scan_ctrl_test;
  localparam int NCH     = 8;
  localparam int RW      = 12;
  localparam int SPACING = 80;
  localparam int TIMEOUT = 64;
  localparam int NROWS   = 6;

  // row: {seed[11:0], dropped channel[3:0] (8 = none), eoc delay[7:0]}
  localparam logic [23:0] ROWS [NROWS] = '{
    {12'h123, 4'd8, 8'd30},
    {12'h4A0, 4'd3, 8'd5},
    {12'hF0F, 4'd8, 8'd45},
    {12'h0C5, 4'd7, 8'd12},
    {12'h7E1, 4'd8, 8'd3},
    {12'h2B4, 4'd8, 8'd30}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_n, sclk, mosi;
  logic miso = 1'b0;
  logic eoc_n = 1'b1;
  logic [NCH*RW-1:0] result;
  logic scan_done, timeout;

  always #2.5 clk = ~clk;

  adc_scan_ctrl #(.SPACING(SPACING), .TIMEOUT(TIMEOUT)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .adc_cs_no(cs_n), .adc_sclk_o(sclk), .adc_mosi_o(mosi), .adc_miso_i(miso),
    .adc_eoc_ni(eoc_n), .result_o(result), .scan_done_o(scan_done), .timeout_o(timeout)
  );

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] sample_of(int row, int ch);
    return ROWS[row][23:12] + 12'(ch * 12'h111);
  endfunction

  // converter model
  int cyc = 0, last_fall = 0, last_rise = 0, rises = 0;
  int scan_idx = -1, exp_ch = 0, cfg_cnt = 0;
  bit have_fall = 0, expect_cfg = 1, prev_ok = 0, prev_drop = 0;
  logic [15:0] sh, cap;
  logic [11:0] out_val = '0;

  always @(posedge clk) cyc++;

  always @(negedge cs_n) begin
    if (have_fall) chk(cyc - last_fall >= SPACING, "R7 spacing", cyc - last_fall, SPACING);
    if (prev_ok) chk(eoc_n == 1'b0, "R5 frame before eoc", eoc_n, 0);
    if (prev_drop) chk(cyc - last_rise >= TIMEOUT, "R8 timeout wait", cyc - last_rise, TIMEOUT);
    have_fall = 1; last_fall = cyc;
    eoc_n = 1'b1;
    sh = {out_val, 4'h0};
    miso = sh[15];
    rises = 0;
  end

  always @(negedge sclk) if (!cs_n) begin
    sh = {sh[14:0], 1'b0};
    miso = sh[15];
  end

  always @(posedge sclk) if (!cs_n) begin
    cap = {cap[14:0], mosi};
    rises++;
  end

  always @(posedge cs_n) if (rst_ni) begin
    int row, ch;
    last_rise = cyc;
    chk(rises == 16, "R4 sclk count", rises, 16);
    prev_ok = 0; prev_drop = 0;
    if (expect_cfg) begin
      chk(cap == 16'hA800, "R2 config frame", cap, 16'hA800);
      expect_cfg = 0; cfg_cnt++; exp_ch = 0;
    end else begin
      ch = int'(cap[15:12]);
      chk(ch == exp_ch && cap[11:0] == 12'h0, "R3 select frame", cap, exp_ch << 12);
      if (ch == 0) scan_idx++;
      row = scan_idx % NROWS;
      exp_ch = (ch + 1) % NCH;
      if (ch != int'(ROWS[row][11:8])) begin
        out_val = sample_of(row, ch);
        prev_ok = 1;
        fork
          begin
            automatic int d = int'(ROWS[row][7:0]);
            repeat (d) @(posedge clk);
            if (cs_n && rst_ni) eoc_n = 1'b0;
          end
        join_none
      end else begin
        prev_drop = 1;
      end
    end
  end

  int to_cnt = 0, sd_cnt = 0;
  always @(negedge clk) if (rst_ni) begin
    if (timeout) to_cnt++;
    if (scan_done) sd_cnt++;
  end

  logic [11:0] exp_reg [NCH];

  task automatic wait_scan();
    @(negedge clk);
    while (!scan_done) @(negedge clk);
  endtask

  task automatic check_regs(input string tag);
    for (int c = 0; c < NCH; c++)
      chk(result[c*RW +: RW] == exp_reg[c], tag, result[c*RW +: RW], exp_reg[c]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) exp_reg[c] = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1 && sclk == 1'b0, "R1 idle pins", {cs_n, sclk}, 2'b10);
    chk(scan_done == 1'b0 && timeout == 1'b0, "R1 pulses low", {scan_done, timeout}, 0);
    check_regs("R1 regs zero");
    rst_ni = 1'b1;

    for (int r = 0; r < NROWS - 1; r++) begin
      wait_scan();
      for (int c = 0; c < NCH; c++)
        if (c != int'(ROWS[r][11:8])) exp_reg[c] = sample_of(r, c);
      check_regs(ROWS[r][11:8] == 4'd8 ? "R6 scan result" : "R8 dropped slot kept");
      @(negedge clk);
      chk(scan_done == 1'b0, "R9 single pulse", scan_done, 0);
    end
    chk(sd_cnt == NROWS - 1, "R9 pulses per scan", sd_cnt, NROWS - 1);
    chk(to_cnt == 2, "R8 timeout pulses", to_cnt, 2);
    chk(cfg_cnt == 1, "R2 config once", cfg_cnt, 1);

    // R10 reset in the middle of operation
    repeat (37) @(negedge clk);
    rst_ni = 1'b0;
    expect_cfg = 1; scan_idx = -1; exp_ch = 0;
    have_fall = 0; prev_ok = 0; prev_drop = 0;
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCH; c++) exp_reg[c] = '0;
    chk(cs_n == 1'b1 && sclk == 1'b0, "R10 pins in reset", {cs_n, sclk}, 2'b10);
    check_regs("R10 regs cleared");
    rst_ni = 1'b1;
    wait_scan();
    for (int c = 0; c < NCH; c++) exp_reg[c] = sample_of(0, c);
    check_regs("R10 rescan");
    chk(cfg_cnt == 2, "R10 config resent", cfg_cnt, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule